// File: doc/BRIEF.md
# PHY Link Status Change Monitor

This block polls a group of Ethernet PHY ports through a generic management-register read handshake and keeps one alive/dead flag per port. A pass is started with a one-cycle `poll_go`. The ports are visited in index order. For each port, the flag left by the previous pass decides which registers are read. A port that is currently alive only needs its link confirmed. A dead port must first show that its reset has finished. It must then show that autonegotiation is done, or that autonegotiation is switched off. Only after that is its link bit believed.

Whenever a port is found with a link, the block works out its speed and duplex from the PHY-specific status word. It re-reads that word until the PHY marks the result as resolved. The re-reads are spaced by a programmable wait counted in clock cycles, and their number is capped. Link-gained and link-lost events come out as one-cycle pulses per port. When a pass finishes, the number of live ports is presented together with a one-cycle done strobe. The transport that carries the reads, such as MDIO, is outside the block. So is any grouping of ports behind a MAC.

Top module: `phy_link_monitor`

## Requirements
- R1: A port whose flag is alive is read only at the specific-status register (default 17). If its link bit (default bit 10) reads 0, the flag is cleared and `link_lost` pulses for that port for one cycle.
- R2: A port whose flag is dead is first read at the basic status register (default 1). If the reset-complete bit (default bit 6) reads 0, the port gets no further reads in that pass.
- R3: A dead port with reset complete is next read at the control register (default 0). The specific-status register is read only if the autonegotiation-enable bit (default control bit 12) is 0, or if the autonegotiation-done bit (default basic-status bit 5) read earlier was 1.
- R4: A dead port whose specific status then shows the link bit set is marked alive, and `link_gained` pulses for that port for one cycle.
- R5: For every port found with a link in a pass, specific status is re-read until the resolved bit (default bit 11) is 1. Consecutive reads of that port are at least WAIT_CYCLES cycles apart. At most MAX_READS reads are made in total, with the link read counting as the first. When the limit is reached, speed and duplex are taken from the last word read.
- R6: The speed is taken from the two-bit field at bits 15:14 of specific status and reported in `port_speed` (two bits per port). Raw 0 is reported as 0 (10 Mb/s), raw 1 as 1 (100 Mb/s) and raw 2 as 2 (1000 Mb/s). Raw 3 is reported as 0.
- R7: `port_full_dx` is 1 when specific-status bit 13 of the word used for speed is 1, and 0 otherwise.
- R8: After the last port of a pass, `pass_done` is high for exactly one cycle. In that same cycle `live_count` equals the number of set bits in `port_alive`.
- R9: After reset, every port is dead, there are no events, `live_count` is 0, `pass_done` is 0 and no read is requested.
- R10: `mgmt_req` stays high, and the address it carries stays unchanged, until `mgmt_ack` is seen. No read is requested between passes.
- R11: Port i is addressed at PHY address PHY_BASE + i, and only the three configured register numbers are ever requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_go | input | 1 | Starts one polling pass when the block is idle |
| mgmt_req | output | 1 | Read request, held until acknowledged |
| mgmt_phy | output | PHY_ADDR_W | PHY address of the request |
| mgmt_reg | output | REG_W | Register number of the request |
| mgmt_ack | input | 1 | One-cycle read completion |
| mgmt_rdata | input | DATA_W | Read data, valid with `mgmt_ack` |
| port_alive | output | NUM_PORTS | Alive flag per port |
| link_gained | output | NUM_PORTS | One-cycle link-gained pulse per port |
| link_lost | output | NUM_PORTS | One-cycle link-lost pulse per port |
| port_speed | output | 2*NUM_PORTS | Resolved speed code per port |
| port_full_dx | output | NUM_PORTS | Resolved full-duplex flag per port |
| live_count | output | CNT_W | Live port count at the end of a pass |
| pass_done | output | 1 | One-cycle end-of-pass strobe |

## Verification
Four passes are run against a model of four PHYs. Each pass mixes ports so that every branch of the read chain is taken: reset still running, autonegotiation pending, autonegotiation disabled, link kept, link dropped and link gained. The per-port read counts seen at the responder separate a port that was skipped early from one that was read too far. One port withholds its resolved bit for a few reads and, in a later pass, for ever. This separates normal retry spacing from the read cap and from the use of the last word. The speed codes include the invalid raw value 3 next to 0, 1 and 2.

// File: rtl/phy_mon_pkg.sv
package phy_mon_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_REQ,
        ST_WAIT,
        ST_NEXT,
        ST_DONE
    } seq_st_t;

    typedef enum logic [2:0] {
        RD_LIVE,
        RD_BASIC,
        RD_CTRL,
        RD_LINK,
        RD_RESOLVE
    } rd_kind_t;

    typedef struct packed {
        logic       link;
        logic       resolved;
        logic       fdx;
        logic [1:0] spd_raw;
    } spec_fields_t;

    function automatic logic [1:0] map_speed(input logic [1:0] raw);
        return (raw == 2'd3) ? 2'd0 : raw;
    endfunction

endpackage

// File: rtl/phy_mon_wait.sv
module phy_mon_wait #(
    parameter int WAIT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    localparam int TW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES + 1) : 1;
    localparam logic [TW-1:0] LOAD = TW'(WAIT_CYCLES - 1);

    logic [TW-1:0] cnt;
    logic          busy;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= LOAD;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/phy_mon_ports.sv
module phy_mon_ports #(
    parameter int N     = 4,
    parameter int IDX_W = 2,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] sel,
    input  logic             mark_up,
    input  logic             mark_down,
    input  logic             latch_res,
    input  logic [1:0]       res_spd,
    input  logic             res_fdx,
    output logic [N-1:0]     alive,
    output logic [N-1:0]     gained,
    output logic [N-1:0]     lost,
    output logic [2*N-1:0]   speed,
    output logic [N-1:0]     fdx,
    output logic [CW-1:0]    alive_cnt
);
    for (genvar i = 0; i < N; i++) begin : g_port
        logic hit;
        assign hit = (sel == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                alive[i]         <= 1'b0;
                gained[i]        <= 1'b0;
                lost[i]          <= 1'b0;
                speed[2*i +: 2]  <= 2'd0;
                fdx[i]           <= 1'b0;
            end else begin
                gained[i] <= hit && mark_up;
                lost[i]   <= hit && mark_down;
                if (hit && mark_up)        alive[i] <= 1'b1;
                else if (hit && mark_down) alive[i] <= 1'b0;
                if (hit && latch_res) begin
                    speed[2*i +: 2] <= res_spd;
                    fdx[i]          <= res_fdx;
                end
            end
        end
    end

    always_comb begin
        alive_cnt = '0;
        for (int k = 0; k < N; k++) begin
            alive_cnt = alive_cnt + CW'(alive[k]);
        end
    end
endmodule

// File: rtl/phy_link_monitor.sv
module phy_link_monitor
    import phy_mon_pkg::*;
#(
    parameter int NUM_PORTS    = 4,
    parameter int PHY_ADDR_W   = 5,
    parameter int PHY_BASE     = 1,
    parameter int REG_W        = 5,
    parameter int DATA_W       = 16,
    parameter int REG_CTRL     = 0,
    parameter int REG_BASIC    = 1,
    parameter int REG_SPEC     = 17,
    parameter int ANEN_BIT     = 12,
    parameter int ANDONE_BIT   = 5,
    parameter int RSTDONE_BIT  = 6,
    parameter int LINK_BIT     = 10,
    parameter int RESOLVED_BIT = 11,
    parameter int FDX_BIT      = 13,
    parameter int SPD_LSB      = 14,
    parameter int MAX_READS    = 200,
    parameter int WAIT_CYCLES  = 16,
    localparam int CNT_W       = $clog2(NUM_PORTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   poll_go,
    output logic                   mgmt_req,
    output logic [PHY_ADDR_W-1:0]  mgmt_phy,
    output logic [REG_W-1:0]       mgmt_reg,
    input  logic                   mgmt_ack,
    input  logic [DATA_W-1:0]      mgmt_rdata,
    output logic [NUM_PORTS-1:0]   port_alive,
    output logic [NUM_PORTS-1:0]   link_gained,
    output logic [NUM_PORTS-1:0]   link_lost,
    output logic [2*NUM_PORTS-1:0] port_speed,
    output logic [NUM_PORTS-1:0]   port_full_dx,
    output logic [CNT_W-1:0]       live_count,
    output logic                   pass_done
);
    localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int RD_W  = $clog2(MAX_READS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PORTS - 1);
    localparam logic [RD_W:0]    READ_CAP = (RD_W + 1)'(MAX_READS);

    seq_st_t          st, st_n;
    rd_kind_t         kind, kind_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic [RD_W-1:0]  reads, reads_n;
    logic             an_done_q, an_done_n;
    logic             mark_up, mark_down, latch_res, wait_go, wait_done;
    logic [RD_W:0]    reads_now;
    logic [CNT_W-1:0] alive_cnt;
    logic [CNT_W-1:0] live_q;
    logic             done_q;
    spec_fields_t     sf;

    assign sf.link     = mgmt_rdata[LINK_BIT];
    assign sf.resolved = mgmt_rdata[RESOLVED_BIT];
    assign sf.fdx      = mgmt_rdata[FDX_BIT];
    assign sf.spd_raw  = mgmt_rdata[SPD_LSB +: 2];

    assign reads_now = (kind == RD_RESOLVE) ? ({1'b0, reads} + 1'b1) : (RD_W + 1)'(1);

    always_comb begin
        st_n      = st;
        kind_n    = kind;
        idx_n     = idx;
        reads_n   = reads;
        an_done_n = an_done_q;
        mark_up   = 1'b0;
        mark_down = 1'b0;
        latch_res = 1'b0;
        wait_go   = 1'b0;
        case (st)
            ST_IDLE: if (poll_go) begin
                idx_n = '0;
                st_n  = ST_PICK;
            end
            ST_PICK: begin
                kind_n = port_alive[idx] ? RD_LIVE : RD_BASIC;
                st_n   = ST_REQ;
            end
            ST_REQ: if (mgmt_ack) begin
                case (kind)
                    RD_BASIC: begin
                        if (!mgmt_rdata[RSTDONE_BIT]) begin
                            st_n = ST_NEXT;
                        end else begin
                            an_done_n = mgmt_rdata[ANDONE_BIT];
                            kind_n    = RD_CTRL;
                        end
                    end
                    RD_CTRL: begin
                        if (!mgmt_rdata[ANEN_BIT] || an_done_q) kind_n = RD_LINK;
                        else                                   st_n   = ST_NEXT;
                    end
                    default: begin
                        if ((kind == RD_RESOLVE) || sf.link) begin
                            mark_up = (kind == RD_LINK);
                            reads_n = reads_now[RD_W-1:0];
                            if (sf.resolved || (reads_now >= READ_CAP)) begin
                                latch_res = 1'b1;
                                st_n      = ST_NEXT;
                            end else begin
                                wait_go = 1'b1;
                                st_n    = ST_WAIT;
                            end
                        end else begin
                            mark_down = (kind == RD_LIVE);
                            st_n      = ST_NEXT;
                        end
                    end
                endcase
            end
            ST_WAIT: if (wait_done) begin
                kind_n = RD_RESOLVE;
                st_n   = ST_REQ;
            end
            ST_NEXT: begin
                if (idx == LAST_IDX) begin
                    st_n = ST_DONE;
                end else begin
                    idx_n = idx + 1'b1;
                    st_n  = ST_PICK;
                end
            end
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= RD_BASIC;
            idx       <= '0;
            reads     <= '0;
            an_done_q <= 1'b0;
            live_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            st        <= st_n;
            kind      <= kind_n;
            idx       <= idx_n;
            reads     <= reads_n;
            an_done_q <= an_done_n;
            done_q    <= (st == ST_DONE);
            if (st == ST_DONE) live_q <= alive_cnt;
        end
    end

    assign mgmt_req = (st == ST_REQ);
    assign mgmt_phy = PHY_ADDR_W'(PHY_BASE) + PHY_ADDR_W'(idx);

    always_comb begin
        case (kind)
            RD_BASIC: mgmt_reg = REG_W'(REG_BASIC);
            RD_CTRL:  mgmt_reg = REG_W'(REG_CTRL);
            default:  mgmt_reg = REG_W'(REG_SPEC);
        endcase
    end

    assign live_count = live_q;
    assign pass_done  = done_q;

    phy_mon_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .start (wait_go),
        .done  (wait_done)
    );

    phy_mon_ports #(.N(NUM_PORTS), .IDX_W(IDX_W), .CW(CNT_W)) u_ports (
        .clk       (clk),
        .rst       (rst),
        .sel       (idx),
        .mark_up   (mark_up),
        .mark_down (mark_down),
        .latch_res (latch_res),
        .res_spd   (map_speed(sf.spd_raw)),
        .res_fdx   (sf.fdx),
        .alive     (port_alive),
        .gained    (link_gained),
        .lost      (link_lost),
        .speed     (port_speed),
        .fdx       (port_full_dx),
        .alive_cnt (alive_cnt)
    );
endmodule

// File: rtl/phy_link_monitor_chk.sv
module phy_link_monitor_chk #(
    parameter int N  = 4,
    parameter int CW = 3,
    parameter int PW = 5,
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          mgmt_req,
    input logic [PW-1:0] mgmt_phy,
    input logic [RW-1:0] mgmt_reg,
    input logic          mgmt_ack,
    input logic [N-1:0]  port_alive,
    input logic [N-1:0]  link_gained,
    input logic [N-1:0]  link_lost,
    input logic [CW-1:0] live_count,
    input logic          pass_done
);
    // R4: a flag rises exactly where a gained pulse is shown
    a_r4_rise_with_gain: assert property (@(posedge clk) disable iff (rst)
        (port_alive & ~$past(port_alive)) == link_gained);

    // R1: a flag falls exactly where a lost pulse is shown
    a_r1_fall_with_lost: assert property (@(posedge clk) disable iff (rst)
        ($past(port_alive) & ~port_alive) == link_lost);

    // R8: live count agrees with the flags at the strobe
    a_r8_count_at_done: assert property (@(posedge clk) disable iff (rst)
        pass_done |-> (32'(live_count) == $countones(port_alive)));

    // R8: strobe lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done);

    // R10: request and address hold until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_phy) && $stable(mgmt_reg)));

    // R10: no request is open while the pass strobe shows
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        pass_done |-> !mgmt_req);
endmodule

bind phy_link_monitor phy_link_monitor_chk #(
    .N(NUM_PORTS), .CW(CNT_W), .PW(PHY_ADDR_W), .RW(REG_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mgmt_req    (mgmt_req),
    .mgmt_phy    (mgmt_phy),
    .mgmt_reg    (mgmt_reg),
    .mgmt_ack    (mgmt_ack),
    .port_alive  (port_alive),
    .link_gained (link_gained),
    .link_lost   (link_lost),
    .live_count  (live_count),
    .pass_done   (pass_done)
);

// File: tb/phy_link_monitor_bench.sv
module phy_link_monitor_bench;
    localparam int NP   = 4;
    localparam int BASE = 1;
    localparam int WAIT = 16;
    localparam int MAXR = 200;
    localparam int CW   = $clog2(NP + 1);
    localparam int EK_GAIN = 0, EK_LOST = 1, EK_DONE = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          poll_go = 1'b0;
    logic          mgmt_req;
    logic [4:0]    mgmt_phy, mgmt_reg;
    logic          mgmt_ack = 1'b0;
    logic [15:0]   mgmt_rdata = '0;
    logic [NP-1:0] port_alive, link_gained, link_lost, port_full_dx;
    logic [2*NP-1:0] port_speed;
    logic [CW-1:0] live_count;
    logic          pass_done;

    always #2 clk = ~clk;

    phy_link_monitor #(.NUM_PORTS(NP), .PHY_BASE(BASE), .MAX_READS(MAXR), .WAIT_CYCLES(WAIT))
    u_phy_link_monitor (
        .clk(clk), .rst(rst), .poll_go(poll_go),
        .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
        .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata),
        .port_alive(port_alive), .link_gained(link_gained), .link_lost(link_lost),
        .port_speed(port_speed), .port_full_dx(port_full_dx),
        .live_count(live_count), .pass_done(pass_done)
    );

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;

    typedef struct { int kind; int port; int val; } exp_t;
    exp_t sbq[$];
    bit done_seen = 0;

    // PHY model
    logic [15:0] m_ctrl[NP], m_basic[NP], m_spec[NP];
    int m_unres[NP];
    int rd_ctrl[NP], rd_basic[NP], rd_spec[NP], last_spec[NP], min_gap[NP];
    int bad_addr = 0;

    function automatic logic [15:0] spec_w(bit link, bit res, bit fdx, int spd);
        return (16'(spd) << 14) | (16'(fdx) << 13) | (16'(res) << 11) | (16'(link) << 10);
    endfunction
    function automatic logic [15:0] basic_w(bit rdone, bit adone);
        return (16'(rdone) << 6) | (16'(adone) << 5);
    endfunction
    function automatic logic [15:0] ctrl_w(bit anen);
        return 16'(anen) << 12;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int p = 0; p < NP; p++) begin
            rd_ctrl[p] = 0; rd_basic[p] = 0; rd_spec[p] = 0;
            last_spec[p] = -1; min_gap[p] = 1000000;
        end
    endtask

    always @(posedge clk) cyc++;

    // responder: fixed latency, one ack per request
    initial begin
        int lat = 0;
        forever begin
            @(posedge clk); #1;
            if (mgmt_ack) begin
                mgmt_ack = 1'b0;
            end else if (mgmt_req) begin
                if (lat == 2) begin
                    int p;
                    lat = 0;
                    p = int'(mgmt_phy) - BASE;
                    mgmt_rdata = '0;
                    if (p < 0 || p >= NP) begin
                        bad_addr++;
                    end else if (mgmt_reg == 5'd0) begin
                        rd_ctrl[p]++; mgmt_rdata = m_ctrl[p];
                    end else if (mgmt_reg == 5'd1) begin
                        rd_basic[p]++; mgmt_rdata = m_basic[p];
                    end else if (mgmt_reg == 5'd17) begin
                        rd_spec[p]++;
                        if (last_spec[p] >= 0 && (cyc - last_spec[p]) < min_gap[p])
                            min_gap[p] = cyc - last_spec[p];
                        last_spec[p] = cyc;
                        mgmt_rdata = m_spec[p];
                        if (m_unres[p] > 0) begin
                            mgmt_rdata[11] = 1'b0;
                            m_unres[p]--;
                        end
                    end else begin
                        bad_addr++;
                    end
                    mgmt_ack = 1'b1;
                end else begin
                    lat++;
                end
            end else begin
                lat = 0;
            end
        end
    end

    // monitor: pops scoreboard as events appear
    task automatic take(int kind, int port, int val);
        string req;
        req = (kind == EK_GAIN) ? "R4" : (kind == EK_LOST) ? "R1" : "R8";
        total++;
        if (sbq.size() == 0) begin
            bad++;
            $display("FAIL %s unexpected event actual kind=%0d port=%0d val=%0d expected none",
                     req, kind, port, val);
        end else begin
            exp_t e;
            e = sbq.pop_front();
            if (e.kind != kind || e.port != port || e.val != val) begin
                bad++;
                $display("FAIL %s event actual kind=%0d port=%0d val=%0d expected kind=%0d port=%0d val=%0d",
                         req, kind, port, val, e.kind, e.port, e.val);
            end
        end
    endtask

    always @(negedge clk) if (!rst) begin
        for (int i = 0; i < NP; i++) begin
            if (link_gained[i]) take(EK_GAIN, i, 0);
            if (link_lost[i])   take(EK_LOST, i, 0);
        end
        if (pass_done) begin
            take(EK_DONE, 0, int'(live_count));
            done_seen = 1;
        end
    end

    task automatic push(int kind, int port, int val);
        exp_t e;
        e.kind = kind; e.port = port; e.val = val;
        sbq.push_back(e);
    endtask

    task automatic run_pass();
        clear_counts();
        done_seen = 0;
        @(negedge clk); poll_go = 1'b1;
        @(negedge clk); poll_go = 1'b0;
        while (!done_seen) @(negedge clk);
        @(negedge clk);
        chk("R8 scoreboard drained", sbq.size(), 0);
        chk("R10 no request after pass", int'(mgmt_req), 0);
        chk("R11 address range", bad_addr, 0);
    endtask

    function automatic int spd(int p);
        return int'(port_speed[2*p +: 2]);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=expired expected=complete");
        finish_run();
    end

    initial begin
        for (int p = 0; p < NP; p++) m_unres[p] = 0;
        // pass 1 setup
        m_ctrl[0] = ctrl_w(1); m_basic[0] = basic_w(1, 1); m_spec[0] = spec_w(1, 1, 1, 2);
        m_ctrl[1] = ctrl_w(1); m_basic[1] = basic_w(0, 1); m_spec[1] = spec_w(1, 1, 1, 1);
        m_ctrl[2] = ctrl_w(1); m_basic[2] = basic_w(1, 0); m_spec[2] = spec_w(1, 1, 1, 1);
        m_ctrl[3] = ctrl_w(0); m_basic[3] = basic_w(1, 0); m_spec[3] = spec_w(1, 1, 0, 3);
        clear_counts();
        repeat (5) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 alive", int'(port_alive), 0);
        chk("R9 live_count", int'(live_count), 0);
        chk("R9 pass_done", int'(pass_done), 0);
        chk("R9 mgmt_req", int'(mgmt_req), 0);
        repeat (4) @(negedge clk);
        chk("R10 idle no request", rd_basic[0] + rd_spec[0], 0);

        // pass 1
        push(EK_GAIN, 0, 0); push(EK_GAIN, 3, 0); push(EK_DONE, 0, 2);
        run_pass();
        chk("R4 alive after pass 1", int'(port_alive), 4'b1001);
        chk("R6 speed port0 1000", spd(0), 2);
        chk("R7 duplex port0 full", int'(port_full_dx[0]), 1);
        chk("R6 speed port3 raw3", spd(3), 0);
        chk("R7 duplex port3 half", int'(port_full_dx[3]), 0);
        chk("R2 port1 no ctrl read", rd_ctrl[1], 0);
        chk("R2 port1 no spec read", rd_spec[1], 0);
        chk("R3 port2 ctrl read", rd_ctrl[2], 1);
        chk("R3 port2 no spec read", rd_spec[2], 0);
        chk("R3 port3 spec read with an off", rd_spec[3], 1);

        // pass 2
        m_spec[0] = spec_w(0, 1, 1, 2);
        m_spec[3] = spec_w(1, 1, 1, 1); m_unres[3] = 3;
        m_basic[2] = basic_w(1, 1); m_spec[2] = spec_w(1, 1, 0, 1);
        push(EK_LOST, 0, 0); push(EK_GAIN, 2, 0); push(EK_DONE, 0, 2);
        run_pass();
        chk("R1 alive after pass 2", int'(port_alive), 4'b1100);
        chk("R1 port3 no basic read", rd_basic[3], 0);
        chk("R1 port0 spec only", rd_basic[0] + rd_ctrl[0], 0);
        chk("R5 port3 retry reads", rd_spec[3], 4);
        chk("R5 port3 spacing", int'(min_gap[3] >= WAIT), 1);
        chk("R6 speed port3 100", spd(3), 1);
        chk("R7 duplex port3 full", int'(port_full_dx[3]), 1);
        chk("R6 speed port2 100", spd(2), 1);
        chk("R7 duplex port2 half", int'(port_full_dx[2]), 0);

        // pass 3
        m_spec[3] = spec_w(1, 1, 1, 2); m_unres[3] = 100000;
        m_basic[1] = basic_w(1, 1); m_spec[1] = spec_w(1, 1, 1, 0);
        push(EK_GAIN, 1, 0); push(EK_DONE, 0, 3);
        run_pass();
        m_unres[3] = 0;
        chk("R5 read cap", rd_spec[3], MAXR);
        chk("R5 last word speed", spd(3), 2);
        chk("R5 last word duplex", int'(port_full_dx[3]), 1);
        chk("R6 speed port1 10", spd(1), 0);
        chk("R4 alive after pass 3", int'(port_alive), 4'b1110);

        // pass 4: no changes, dead port with reset pending
        m_basic[0] = basic_w(0, 1); m_spec[0] = spec_w(1, 1, 1, 2);
        push(EK_DONE, 0, 3);
        run_pass();
        chk("R2 port0 basic only", rd_basic[0], 1);
        chk("R2 port0 no ctrl", rd_ctrl[0], 0);
        chk("R1 alive kept", int'(port_alive), 4'b1110);

        finish_run();
    end
endmodule